// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block moves a synchronous DRAM into self-refresh and brings it back out. It drives the clock-enable pin, the four command pins (chip select, row strobe, column strobe, write enable) and address bit 10. Each command goes out in a fixed order, and every gap is measured in clock cycles.

On entry the block closes every open bank with a precharge-all command. It then waits the precharge time and issues the refresh command in the same cycle that clock-enable drops. While the device is in self-refresh, clock-enable stays low and the command pins carry inhibit. The device may stay in this state for any length of time.

On exit the block waits until the host reports a stable clock. It then raises clock-enable and drives only no-operation commands for the exit-recovery time. After that it issues one auto-refresh to restart the device's refresh time base. The host sees a one-cycle completion pulse only after that auto-refresh.

Each gap is a parameter in nanoseconds. It is turned into a cycle count with a ceiling division by the clock period. The exit-recovery count never goes below two cycles, and the precharge count never goes below one cycle.

Top module: `sdram_sr_seq`

## Requirements
- R1: After reset, clock-enable is high, the command is no-operation (chip select 0, row 1, column 1, write 1), and both sr_active and sr_done are low.
- R2: An entry request sampled while the block is idle puts a precharge-all on the pins in the next cycle. Precharge-all is chip select 0, row 0, column 1, write 0, with a10 high.
- R3: The self-refresh command appears exactly N_RP cycles after the precharge, with only no-operation in between. That command is chip select 0, row 0, column 0, write 1, issued in the same cycle that clock-enable falls.
- R4: After the self-refresh command, clock-enable stays low and the pins carry inhibit (chip select 1, others 1) until exit. sr_active stays high for that whole time.
- R5: Clock-enable rises only on an edge at which clk_stable is high. An exit request that arrives while clk_stable is low is held until clk_stable goes high.
- R6: Once clock-enable has risen, every command is no-operation for N_XSR cycles. In the cycle after that an auto-refresh (same encoding as in R3) is issued with clock-enable high.
- R7: sr_done is high for exactly one cycle, the one after the auto-refresh. sr_active is low from the cycle in which clock-enable rises.
- R8: An exit request made while the block is not in self-refresh is dropped. It never causes a later exit.
- R9: An entry request made at any time other than idle is ignored: each entry/exit sequence contains exactly one precharge.
- R10: N_RP = max(1, ceil(TRP_NS/tCK)) and N_XSR = max(2, ceil(TXSR_NS/tCK)). A very short exit time still gives two recovery cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_enter_req | input | 1 | Host request to enter self-refresh |
| sr_exit_req | input | 1 | Host request to leave self-refresh |
| clk_stable | input | 1 | Host indication that the clock is stable |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10 (all-banks select) |
| sr_active | output | 1 | Device is held in self-refresh |
| sr_done | output | 1 | One-cycle pulse when the exit sequence ends |

## Verification
Full entry and exit cycles are run with random idle times, random residence times and random exit styles. Some exits come with the clock already stable. Others have clk_stable held low for a few cycles, which separates a remembered exit request from one that acts at once.

Spurious exit pulses in idle and extra entry pulses during the entry wait and during self-refresh separate dropped requests from latched ones.

A second instance runs with very short timing values. It shows the two-cycle floor on exit recovery and the single-cycle precharge gap, which the main instance's counts cannot show.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_SRE,
        ST_SELF,
        ST_XSR,
        ST_AREF,
        ST_DONE
    } sr_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_INHIBIT,
        CMD_PRECHARGE,
        CMD_REFRESH
    } sr_cmd_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sdram_pins_t;

    // ceil(ns / tCK) with tCK in picoseconds, never below floor_min
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned tck_ps,
                                                 input int unsigned floor_min);
        int unsigned c;
        c = (ns * 1000 + tck_ps - 1) / tck_ps;
        if (c < floor_min) c = floor_min;
        return c;
    endfunction

    function automatic sdram_pins_t encode_cmd(input sr_cmd_e cmd, input logic cke_lvl);
        sdram_pins_t p;
        p.cke = cke_lvl;
        p.a10 = 1'b0;
        case (cmd)
            CMD_INHIBIT:   begin p.cs_n = 1'b1; p.ras_n = 1'b1; p.cas_n = 1'b1; p.we_n = 1'b1; end
            CMD_PRECHARGE: begin p.cs_n = 1'b0; p.ras_n = 1'b0; p.cas_n = 1'b1; p.we_n = 1'b0; p.a10 = 1'b1; end
            CMD_REFRESH:   begin p.cs_n = 1'b0; p.ras_n = 1'b0; p.cas_n = 1'b0; p.we_n = 1'b1; end
            default:       begin p.cs_n = 1'b0; p.ras_n = 1'b1; p.cas_n = 1'b1; p.we_n = 1'b1; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sr_gap_timer.sv
module sr_gap_timer
    import sr_seq_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          gap_last
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign gap_last = (cnt <= CW'(1));

    // R6
    tmr_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
    import sr_seq_pkg::*;
#(
    parameter int unsigned N_RP  = 3,
    parameter int unsigned N_XSR = 10,
    parameter int          CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enter_req,
    input  logic          exit_req,
    input  logic          clk_stable,
    input  logic          gap_last,
    output logic          timer_load,
    output logic [CW-1:0] timer_val,
    output sr_state_e     state,
    output logic          sr_active,
    output logic          sr_done
);

    localparam bit RP_WAIT = (N_RP > 1);

    sr_state_e state_nx;
    logic      exit_pend;
    logic      exit_go;

    assign exit_go = (exit_pend || exit_req) && clk_stable;

    always_comb begin
        state_nx   = state;
        timer_load = 1'b0;
        timer_val  = CW'(N_XSR);
        case (state)
            ST_IDLE:    if (enter_req) state_nx = ST_PRE;
            ST_PRE: begin
                timer_load = 1'b1;
                timer_val  = CW'(N_RP - 1);
                state_nx   = RP_WAIT ? ST_WAIT_RP : ST_SRE;
            end
            ST_WAIT_RP: if (gap_last) state_nx = ST_SRE;
            ST_SRE:     state_nx = ST_SELF;
            ST_SELF: begin
                if (exit_go) begin
                    state_nx   = ST_XSR;
                    timer_load = 1'b1;
                    timer_val  = CW'(N_XSR);
                end
            end
            ST_XSR:     if (gap_last) state_nx = ST_AREF;
            ST_AREF:    state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            exit_pend <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_SELF && state_nx == ST_SELF)
                exit_pend <= exit_pend | exit_req;
            else
                exit_pend <= 1'b0;
        end
    end

    assign sr_active = (state == ST_SELF);
    assign sr_done   = (state == ST_DONE);

    // R5
    self_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SELF && !clk_stable) |=> (state == ST_SELF));

    // R9
    self_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SELF) |=> (state == ST_SELF || state == ST_XSR));

    // R7
    done_after_aref_chk: assert property (@(posedge clk) disable iff (rst)
        sr_done |-> ($past(state) == ST_AREF));

endmodule

// File: rtl/sr_cmd_drive.sv
module sr_cmd_drive
    import sr_seq_pkg::*;
#(
    parameter int unsigned N_RP  = 3,
    parameter int unsigned N_XSR = 10,
    parameter int          CW    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  sr_state_e   state,
    output sdram_pins_t pins
);

    always_comb begin
        case (state)
            ST_PRE:  pins = encode_cmd(CMD_PRECHARGE, 1'b1);
            ST_SRE:  pins = encode_cmd(CMD_REFRESH,   1'b0);
            ST_SELF: pins = encode_cmd(CMD_INHIBIT,   1'b0);
            ST_AREF: pins = encode_cmd(CMD_REFRESH,   1'b1);
            default: pins = encode_cmd(CMD_NOP,       1'b1);
        endcase
    end

    // gap trackers observing the pins, used by the checks below
    localparam int SW = CW + 1;
    logic [SW-1:0] since_pre;
    logic [SW-1:0] since_rise;
    logic          cke_q;
    logic          is_pre;
    logic          is_ref;

    assign is_pre = !pins.cs_n && !pins.ras_n && pins.cas_n && !pins.we_n;
    assign is_ref = !pins.cs_n && !pins.ras_n && !pins.cas_n && pins.we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_pre  <= '0;
            since_rise <= '0;
            cke_q      <= 1'b1;
        end else begin
            cke_q <= pins.cke;
            if (is_pre)
                since_pre <= SW'(1);
            else if (since_pre != '0 && since_pre != '1)
                since_pre <= since_pre + 1'b1;
            if (pins.cke && !cke_q)
                since_rise <= SW'(1);
            else if (since_rise != '0 && since_rise != '1)
                since_rise <= since_rise + 1'b1;
        end
    end

    // R2
    pre_a10_chk: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> pins.a10);

    // R3
    sre_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!pins.cke && cke_q) |-> (is_ref && since_pre == SW'(N_RP)));

    // R4
    cke_low_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (!pins.cke && !cke_q) |-> pins.cs_n);

    // R6
    aref_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (is_ref && pins.cke) |-> (since_rise == SW'(N_XSR)));

endmodule

// File: rtl/sdram_sr_seq.sv
module sdram_sr_seq
    import sr_seq_pkg::*;
#(
    parameter int unsigned TCK_PS  = 8000,
    parameter int unsigned TRP_NS  = 20,
    parameter int unsigned TXSR_NS = 75
) (
    input  logic clk,
    input  logic rst,
    input  logic sr_enter_req,
    input  logic sr_exit_req,
    input  logic clk_stable,
    output logic cke,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic a10,
    output logic sr_active,
    output logic sr_done
);

    localparam int unsigned N_RP  = ns_to_cycles(TRP_NS, TCK_PS, 1);
    localparam int unsigned N_XSR = ns_to_cycles(TXSR_NS, TCK_PS, 2);
    localparam int unsigned N_MAX = (N_RP > N_XSR) ? N_RP : N_XSR;
    localparam int          CW    = $clog2(N_MAX + 1);

    sr_state_e     state;
    logic          timer_load;
    logic [CW-1:0] timer_val;
    logic          gap_last;
    sdram_pins_t   pins;

    sr_seq_fsm #(.N_RP(N_RP), .N_XSR(N_XSR), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enter_req  (sr_enter_req),
        .exit_req   (sr_exit_req),
        .clk_stable (clk_stable),
        .gap_last   (gap_last),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .state      (state),
        .sr_active  (sr_active),
        .sr_done    (sr_done)
    );

    sr_gap_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .gap_last (gap_last)
    );

    sr_cmd_drive #(.N_RP(N_RP), .N_XSR(N_XSR), .CW(CW)) u_drive (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .pins  (pins)
    );

    assign cke   = pins.cke;
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign a10   = pins.a10;

endmodule

// File: tb/sdram_sr_seq_tb.sv
`timescale 1ns/1ps
module sdram_sr_seq_tb;

    localparam int unsigned TCK_PS = 8000;

    function automatic int exp_cycles(input int ns, input int tck_ps, input int lo);
        int c;
        c = (ns * 1000 + tck_ps - 1) / tck_ps;
        return (c < lo) ? lo : c;
    endfunction

    localparam int NRP   = exp_cycles(20, TCK_PS, 1);
    localparam int NXSR  = exp_cycles(75, TCK_PS, 2);
    localparam int NRP2  = exp_cycles(5, TCK_PS, 1);
    localparam int NXSR2 = exp_cycles(5, TCK_PS, 2);

    // command codes used by the bench
    localparam int C_NOP = 0, C_INH = 1, C_PRE = 2, C_REF = 3, C_OTH = 4;

    function automatic int cmd_of(input logic cs, input logic ras, input logic cas, input logic we);
        if (cs) return C_INH;
        if (ras && cas && we) return C_NOP;
        if (!ras && cas && !we) return C_PRE;
        if (!ras && !cas && we) return C_REF;
        return C_OTH;
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enter_req = 1'b0, exit_req = 1'b0, clk_stable = 1'b1;
    logic enter2 = 1'b0, exit2 = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, a10, sr_active, sr_done;
    logic cke2, cs2, ras2, cas2, we2, a10_2, act2, done2;

    always #4 clk = ~clk;

    sdram_sr_seq #(.TCK_PS(TCK_PS), .TRP_NS(20), .TXSR_NS(75)) u_dut (
        .clk(clk), .rst(rst), .sr_enter_req(enter_req), .sr_exit_req(exit_req),
        .clk_stable(clk_stable), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .a10(a10), .sr_active(sr_active), .sr_done(sr_done)
    );

    sdram_sr_seq #(.TCK_PS(TCK_PS), .TRP_NS(5), .TXSR_NS(5)) u_dut_short (
        .clk(clk), .rst(rst), .sr_enter_req(enter2), .sr_exit_req(exit2),
        .clk_stable(clk_stable), .cke(cke2), .cs_n(cs2), .ras_n(ras2),
        .cas_n(cas2), .we_n(we2), .a10(a10_2), .sr_active(act2), .sr_done(done2)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- pin monitor (main instance) ----------------
    int  cyc = 0;
    int  pre_cyc = 0, rise_cyc = 0, pre_cnt = 0;
    bit  between_ok = 1, xsr_ok = 1, in_rp = 0, in_xsr = 0;
    logic prev_cke = 1'b1;
    int  prev_cmd = C_NOP;
    logic cs_at_edge = 1'b1;

    always @(posedge clk) cs_at_edge <= clk_stable;

    always @(negedge clk) begin
        int c;
        cyc++;
        if (!rst) begin
            c = cmd_of(cs_n, ras_n, cas_n, we_n);
            if (c == C_PRE) begin
                chk(a10 == 1'b1, "R2", "a10 on precharge", a10, 1);
                pre_cyc = cyc; between_ok = 1; in_rp = 1; pre_cnt++;
            end else if (prev_cke && !cke) begin
                chk(c == C_REF, "R3", "command at cke fall", c, C_REF);
                chk(cyc - pre_cyc == NRP, "R3", "precharge to entry gap", cyc - pre_cyc, NRP);
                chk(between_ok, "R3", "only nop inside tRP", between_ok, 1);
                in_rp = 0;
            end else if (!cke) begin
                chk(c == C_INH, "R4", "command while in self-refresh", c, C_INH);
                chk(sr_active == 1'b1, "R4", "sr_active in self-refresh", sr_active, 1);
            end else if (!prev_cke && cke) begin
                chk(cs_at_edge == 1'b1, "R5", "clk_stable at cke rise", cs_at_edge, 1);
                chk(sr_active == 1'b0, "R7", "sr_active at cke rise", sr_active, 0);
                chk(c == C_NOP, "R6", "command at cke rise", c, C_NOP);
                rise_cyc = cyc; xsr_ok = 1; in_xsr = 1;
            end else if (c == C_REF && cke) begin
                chk(cyc - rise_cyc == NXSR, "R6", "cke rise to auto-refresh gap", cyc - rise_cyc, NXSR);
                chk(xsr_ok, "R6", "only nop inside tXSR", xsr_ok, 1);
                in_xsr = 0;
            end else begin
                if (in_rp && c != C_NOP) between_ok = 0;
                if (in_xsr && c != C_NOP) xsr_ok = 0;
            end
            if (sr_done) begin
                chk(prev_cmd == C_REF && prev_cke, "R7", "done follows auto-refresh", prev_cmd, C_REF);
                chk(pre_cnt == 1, "R9", "precharges per sequence", pre_cnt, 1);
                pre_cnt = 0;
            end
            prev_cmd = c;
            prev_cke = cke;
        end
    end

    // ---------------- short-timing instance monitor ----------------
    int   pre2_cyc = 0, rise2_cyc = 0;
    logic prev_cke2 = 1'b1;

    always @(negedge clk) begin
        int c;
        if (!rst) begin
            c = cmd_of(cs2, ras2, cas2, we2);
            if (c == C_PRE) pre2_cyc = cyc;
            else if (prev_cke2 && !cke2)
                chk(cyc - pre2_cyc == NRP2, "R10", "short precharge gap", cyc - pre2_cyc, NRP2);
            else if (!prev_cke2 && cke2) rise2_cyc = cyc;
            else if (c == C_REF && cke2)
                chk(cyc - rise2_cyc == NXSR2, "R10", "clamped recovery gap", cyc - rise2_cyc, NXSR2);
            prev_cke2 = cke2;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_one(input int it);
        int waited;
        wait_cycles(1 + $urandom % 5);
        if (it % 3 == 0) begin
            exit_req = 1'b1; @(negedge clk); exit_req = 1'b0;   // R8 spurious
            wait_cycles(1 + $urandom % 3);
        end
        enter_req = 1'b1; enter2 = 1'b1;
        @(negedge clk);
        enter_req = 1'b0; enter2 = 1'b0;
        chk(cmd_of(cs_n, ras_n, cas_n, we_n) == C_PRE, "R2", "precharge after entry request",
            cmd_of(cs_n, ras_n, cas_n, we_n), C_PRE);
        if (it % 2 == 1) begin
            enter_req = 1'b1; @(negedge clk); enter_req = 1'b0;  // R9 during tRP
        end
        waited = 0;
        while (!sr_active && waited < 50) begin @(negedge clk); waited++; end
        chk(sr_active == 1'b1, "R4", "reached self-refresh", sr_active, 1);
        wait_cycles(1 + $urandom % 8);
        if (it % 3 == 0)
            chk(cke == 1'b0, "R8", "idle exit request dropped", cke, 0);
        if (it % 2 == 0) begin
            enter_req = 1'b1; @(negedge clk); enter_req = 1'b0;  // R9 in self-refresh
            @(negedge clk);
            chk(cmd_of(cs_n, ras_n, cas_n, we_n) == C_INH && !cke, "R9", "entry request in self-refresh ignored",
                cmd_of(cs_n, ras_n, cas_n, we_n), C_INH);
        end
        if ($urandom % 2 == 1) begin
            clk_stable = 1'b0;
            exit_req = 1'b1; exit2 = 1'b1;
            @(negedge clk);
            exit_req = 1'b0; exit2 = 1'b0;
            wait_cycles(2 + $urandom % 5);
            chk(cke == 1'b0, "R5", "held low without stable clock", cke, 0);
            clk_stable = 1'b1;
            @(negedge clk);
            chk(cke == 1'b1, "R5", "remembered exit after clock stable", cke, 1);
        end else begin
            exit_req = 1'b1; exit2 = 1'b1;
            @(negedge clk);
            exit_req = 1'b0; exit2 = 1'b0;
            chk(cke == 1'b1, "R5", "immediate exit with stable clock", cke, 1);
        end
        waited = 0;
        while (!sr_done && waited < 60) begin @(negedge clk); waited++; end
        chk(sr_done == 1'b1, "R7", "done pulse seen", sr_done, 1);
        @(negedge clk);
        chk(sr_done == 1'b0, "R7", "done lasts one cycle", sr_done, 0);
        chk(cke == 1'b1 && cmd_of(cs_n, ras_n, cas_n, we_n) == C_NOP, "R1", "idle nop after sequence",
            cmd_of(cs_n, ras_n, cas_n, we_n), C_NOP);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cke == 1'b1, "R1", "reset cke", cke, 1);
        chk(cmd_of(cs_n, ras_n, cas_n, we_n) == C_NOP, "R1", "reset command",
            cmd_of(cs_n, ras_n, cas_n, we_n), C_NOP);
        chk(!sr_active && !sr_done, "R1", "reset status", {sr_active, sr_done}, 0);
        // R8: exit request in idle alone does nothing
        exit_req = 1'b1; @(negedge clk); exit_req = 1'b0;
        wait_cycles(3);
        chk(cke == 1'b1 && !sr_active, "R8", "exit in idle ignored", cke, 1);
        for (int it = 0; it < 24; it++) run_one(it);
        finish_run();
    end

endmodule